// File: doc/BRIEF.md
# Write-only I2C target receiver

This block is the receive side of a small write-only I2C target that feeds a multi-channel DAC controller. It samples the bus clock and data lines through synchronisers clocked by a much faster system clock, detects START and STOP conditions, and compares the 7-bit target address against two values. The first value comes from three address straps, and each strap has three levels. The second value is a fixed global address that all such targets share.

After a matching write address, the block shifts in three data bytes and acknowledges each one. When the third byte is complete, it raises a one-cycle strobe together with the 24-bit word. The downstream command decoder takes the word from there. The block acknowledges no read request. It also leaves every byte after the third one without an acknowledge. The data line output is an open-drain pull-low enable, so a high output means the block pulls the line low.

Top module: `wr_only_i2c_rx`

## Requirements
- R1: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. After a STOP the block releases SDA on the next cycle and ignores bus traffic until the next START.
- R2: A bit is taken on each rising edge of SCL. The first bit of a byte is its most significant bit.
- R3: The address byte carries the 7-bit address in bits [7:1] and the read/write flag in bit [0], where 0 means write. With the flag at 0 and the address equal to the strap address, the block pulls SDA low during the 9th clock.
- R4: With the flag at 0 and the address equal to 7'h73, the block also pulls SDA low during the 9th clock, whatever the straps are.
- R5: When the read/write flag is 1, the block leaves SDA released during the 9th clock. It then acknowledges nothing until a new START.
- R6: Any other address gets no acknowledge. None of the bytes that follow it are acknowledged either, and no word strobe is issued.
- R7: After an acknowledged write address, the block pulls SDA low during the 9th clock of each of the first three data bytes. Exactly one cycle of `word_vld_o` follows the third byte. In that cycle `word_o` holds the first byte in [23:16], the second in [15:8] and the third in [7:0]. `word_o` changes only in a strobe cycle.
- R8: Data bytes after the third one in the same transaction are not acknowledged and produce no further strobe.
- R9: Each strap is a 2-bit code: 00 = ground, 01 = floating, 10 = supply, and 11 is treated as floating. For the codes c2, c1, c0, let i = 9*c2 + 3*c1 + c0. The strap address is then 16*(i/4 + 1) + (i mod 4).
- R10: A repeated START or a STOP inside a byte abandons the transaction without a strobe. After a repeated START the next byte is a fresh address byte.
- R11: The SDA pull enable changes only while SCL is low.
- R12: After reset, `sda_pull_o` and `word_vld_o` are 0 and `word_o` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| strap_a2_i | input | 2 | Most significant address strap code |
| strap_a1_i | input | 2 | Middle address strap code |
| strap_a0_i | input | 2 | Least significant address strap code |
| sda_pull_o | output | 1 | 1 = drive the data line low |
| word_vld_o | output | 1 | One-cycle strobe, the received word is valid |
| word_o | output | 24 | Last received 24-bit word |

## Verification
The assertions check several rules on every cycle. The pull enable may change only while the synchronised clock is low. The strobe lasts one cycle and coincides with an acknowledge. The word holds its value between strobes. A STOP releases the line on the next cycle.

The address decode needs the bench's scenarios. These drive random strap codes, the global address, read requests and foreign addresses. Acknowledge counting, the assembled byte order and extra-byte refusal also need whole transactions. So does the abandonment of transactions cut by a STOP or a repeated START, because the outcome shows only at the end of a transaction.

// File: rtl/wrx_pkg.sv
package wrx_pkg;

    localparam int BYTE_W  = 8;
    localparam int ADDR_W  = 7;
    localparam int STRAP_W = 2;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2
    } phase_e;

    // Strap level code to ternary digit; code 2'b11 is read as floating.
    function automatic logic [1:0] strap_digit(input logic [STRAP_W-1:0] code);
        return (code == 2'b11) ? 2'b01 : code;
    endfunction

endpackage

// File: rtl/wrx_sync.sv
module wrx_sync #(
    parameter int           W       = 2,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_comb stg_d[s] = d_i;
        end else begin : g_next
            always_comb stg_d[s] = stg_q[s-1];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[s] <= RST_VAL;
            else        stg_q[s] <= stg_d[s];
        end
    end

    assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/wrx_addr_map.sv
module wrx_addr_map
    import wrx_pkg::*;
(
    input  logic [STRAP_W-1:0] strap_a2_i,
    input  logic [STRAP_W-1:0] strap_a1_i,
    input  logic [STRAP_W-1:0] strap_a0_i,
    output logic [ADDR_W-1:0]  addr_o
);

    logic [4:0] idx;
    logic [2:0] group;

    always_comb begin
        // Ternary index 0..26 over the three straps.
        idx    = 5'd9 * {3'd0, strap_digit(strap_a2_i)}
               + 5'd3 * {3'd0, strap_digit(strap_a1_i)}
               + {3'd0, strap_digit(strap_a0_i)};
        group  = idx[4:2] + 3'd1;
        addr_o = {group, 2'b00, idx[1:0]};
    end

endmodule

// File: rtl/wrx_core.sv
module wrx_core
    import wrx_pkg::*;
#(
    parameter int               DATA_BYTES  = 3,
    parameter logic [ADDR_W-1:0] GLOBAL_ADDR = 7'h73,
    localparam int              WORD_W      = DATA_BYTES * BYTE_W,
    localparam int              IDX_W       = $clog2(DATA_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic [ADDR_W-1:0] own_addr_i,
    output logic              sda_pull_o,
    output logic              word_vld_o,
    output logic [WORD_W-1:0] word_o
);

    localparam logic [3:0]       BITS_PER_BYTE = 4'(BYTE_W);
    localparam logic [IDX_W-1:0] LAST_IDX      = IDX_W'(DATA_BYTES - 1);
    localparam logic [IDX_W-1:0] NUM_BYTES     = IDX_W'(DATA_BYTES);

    typedef struct packed {
        phase_e            phase;
        logic [3:0]        bit_cnt;
        logic              in_ack;
        logic [IDX_W-1:0]  byte_idx;
        logic [BYTE_W-1:0] shreg;
        logic [WORD_W-1:0] acc;
        logic              addr_hit;
        logic              pull;
        logic              vld;
        logic [WORD_W-1:0] word;
        logic              scl_p;
        logic              sda_p;
    } core_st_t;

    core_st_t st_d, st_q;

    logic scl_rise, scl_fall, start_det, stop_det, addr_ok;

    always_comb begin
        scl_rise  =  scl_s & ~st_q.scl_p;
        scl_fall  = ~scl_s &  st_q.scl_p;
        start_det =  scl_s &  st_q.scl_p &  st_q.sda_p & ~sda_s;
        stop_det  =  scl_s &  st_q.scl_p & ~st_q.sda_p &  sda_s;
        addr_ok   = ~st_q.shreg[0] &&
                    ((st_q.shreg[BYTE_W-1:1] == own_addr_i) ||
                     (st_q.shreg[BYTE_W-1:1] == GLOBAL_ADDR));

        st_d       = st_q;
        st_d.vld   = 1'b0;
        st_d.scl_p = scl_s;
        st_d.sda_p = sda_s;

        if (start_det) begin
            st_d.phase    = PH_ADDR;
            st_d.bit_cnt  = '0;
            st_d.in_ack   = 1'b0;
            st_d.byte_idx = '0;
            st_d.acc      = '0;
            st_d.addr_hit = 1'b0;
            st_d.pull     = 1'b0;
        end else if (stop_det) begin
            st_d.phase   = PH_IDLE;
            st_d.bit_cnt = '0;
            st_d.in_ack  = 1'b0;
            st_d.pull    = 1'b0;
        end else if (st_q.phase != PH_IDLE) begin
            if (scl_rise && !st_q.in_ack && st_q.bit_cnt < BITS_PER_BYTE) begin
                st_d.shreg   = {st_q.shreg[BYTE_W-2:0], sda_s};
                st_d.bit_cnt = st_q.bit_cnt + 4'd1;
            end else if (scl_fall) begin
                if (st_q.in_ack) begin
                    // End of the acknowledge clock: release and go on.
                    st_d.in_ack  = 1'b0;
                    st_d.pull    = 1'b0;
                    st_d.bit_cnt = '0;
                    if (st_q.phase == PH_ADDR)
                        st_d.phase = st_q.addr_hit ? PH_DATA : PH_IDLE;
                end else if (st_q.bit_cnt == BITS_PER_BYTE) begin
                    st_d.in_ack = 1'b1;
                    if (st_q.phase == PH_ADDR) begin
                        st_d.addr_hit = addr_ok;
                        st_d.pull     = addr_ok;
                    end else if (st_q.byte_idx < NUM_BYTES) begin
                        st_d.pull     = 1'b1;
                        st_d.acc      = (st_q.acc << BYTE_W) | WORD_W'(st_q.shreg);
                        st_d.byte_idx = st_q.byte_idx + 1'b1;
                        if (st_q.byte_idx == LAST_IDX) begin
                            st_d.vld  = 1'b1;
                            st_d.word = (st_q.acc << BYTE_W) | WORD_W'(st_q.shreg);
                        end
                    end else begin
                        st_d.pull = 1'b0;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.phase <= PH_IDLE;
            st_q.scl_p <= 1'b1;
            st_q.sda_p <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign sda_pull_o = st_q.pull;
    assign word_vld_o = st_q.vld;
    assign word_o     = st_q.word;

endmodule

// File: rtl/wr_only_i2c_rx.sv
module wr_only_i2c_rx
    import wrx_pkg::*;
#(
    parameter int                SYNC_STAGES = 2,
    parameter int                DATA_BYTES  = 3,
    parameter logic [ADDR_W-1:0] GLOBAL_ADDR = 7'h73,
    localparam int               WORD_W      = DATA_BYTES * BYTE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    input  logic [STRAP_W-1:0] strap_a2_i,
    input  logic [STRAP_W-1:0] strap_a1_i,
    input  logic [STRAP_W-1:0] strap_a0_i,
    output logic               sda_pull_o,
    output logic               word_vld_o,
    output logic [WORD_W-1:0]  word_o
);

    logic [1:0]        bus_s;
    logic              scl_s, sda_s;
    logic [ADDR_W-1:0] own_addr;

    wrx_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({scl_i, sda_i}),
        .q_o   (bus_s)
    );

    assign scl_s = bus_s[1];
    assign sda_s = bus_s[0];

    wrx_addr_map addr_map_i (
        .strap_a2_i (strap_a2_i),
        .strap_a1_i (strap_a1_i),
        .strap_a0_i (strap_a0_i),
        .addr_o     (own_addr)
    );

    wrx_core #(.DATA_BYTES(DATA_BYTES), .GLOBAL_ADDR(GLOBAL_ADDR)) core_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_s      (scl_s),
        .sda_s      (sda_s),
        .own_addr_i (own_addr),
        .sda_pull_o (sda_pull_o),
        .word_vld_o (word_vld_o),
        .word_o     (word_o)
    );

endmodule

// File: rtl/wr_only_i2c_rx_chk.sv
module wr_only_i2c_rx_chk #(
    parameter int WORD_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_s,
    input logic              sda_s,
    input logic              sda_pull_o,
    input logic              word_vld_o,
    input logic [WORD_W-1:0] word_o
);

    assert_pull_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull_o) |-> !$past(scl_s));

    assert_strobe_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld_o |=> !word_vld_o);

    assert_word_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !word_vld_o |-> $stable(word_o));

    assert_strobe_acked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld_o |-> sda_pull_o);

    assert_stop_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s) && !$past(sda_s) && sda_s) |=> !sda_pull_o);

endmodule

bind wr_only_i2c_rx wr_only_i2c_rx_chk #(.WORD_W(WORD_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_s      (scl_s),
    .sda_s      (sda_s),
    .sda_pull_o (sda_pull_o),
    .word_vld_o (word_vld_o),
    .word_o     (word_o)
);

// File: tb/wr_only_i2c_rx_tb_top.sv
module wr_only_i2c_rx_tb_top;

    localparam int Q = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_i = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_line;
    logic [1:0]  st2 = 2'b00, st1 = 2'b00, st0 = 2'b00;
    logic        sda_pull_o, word_vld_o;
    logic [23:0] word_o;

    int n_chk = 0, n_fail = 0, strobes = 0, pull_bad = 0;
    logic [23:0] last_word = '0;
    logic        prev_pull = 1'b0;
    logic [7:0]  tx [8];
    logic        ack_r [9];
    bit          done = 0;

    assign sda_line = sda_m & ~sda_pull_o;

    always #10 clk = ~clk;

    wr_only_i2c_rx dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_line),
        .strap_a2_i (st2),
        .strap_a1_i (st1),
        .strap_a0_i (st0),
        .sda_pull_o (sda_pull_o),
        .word_vld_o (word_vld_o),
        .word_o     (word_o)
    );

    // Monitor away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (word_vld_o) begin
                strobes++;
                last_word = word_o;
            end
            if (sda_pull_o != prev_pull && scl_i) pull_bad++;
        end
        prev_pull = sda_pull_o;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(posedge clk);
        #3;
    endtask

    function automatic logic [6:0] exp_addr(input logic [1:0] a2, a1, a0);
        int d2, d1, d0, i;
        d2 = (a2 == 3) ? 1 : a2;
        d1 = (a1 == 3) ? 1 : a1;
        d0 = (a0 == 3) ? 1 : a0;
        i  = d2 * 9 + d1 * 3 + d0;
        return 7'(16 * (i / 4 + 1) + (i % 4));
    endfunction

    task automatic bus_start;
        sda_m = 1'b1; wt(Q);
        scl_i = 1'b1; wt(Q);
        sda_m = 1'b0; wt(Q);
        scl_i = 1'b0; wt(Q);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; wt(Q);
        scl_i = 1'b1; wt(Q);
        sda_m = 1'b1; wt(Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int nb);
        for (int i = 0; i < nb; i++) begin
            sda_m = b[7-i]; wt(Q);
            scl_i = 1'b1;   wt(2*Q);
            scl_i = 1'b0;   wt(Q);
        end
    endtask

    task automatic ack_slot(output logic a);
        sda_m = 1'b1; wt(Q);
        scl_i = 1'b1; wt(Q);
        a = sda_pull_o;
        wt(Q);
        scl_i = 1'b0; wt(Q);
    endtask

    task automatic xfer(input logic [6:0] a, input logic rw, input int n);
        logic ak;
        bus_start();
        send_bits({a, rw}, 8);
        ack_slot(ak); ack_r[0] = ak;
        for (int i = 0; i < n; i++) begin
            send_bits(tx[i], 8);
            ack_slot(ak); ack_r[i+1] = ak;
        end
        bus_stop();
    endtask

    task automatic good_write(input logic [6:0] a, input string req);
        int s0;
        logic [23:0] ew;
        for (int i = 0; i < 3; i++) tx[i] = 8'($urandom);
        ew = {tx[0], tx[1], tx[2]};
        s0 = strobes;
        xfer(a, 1'b0, 3);
        chk(ack_r[0] === 1'b1, {req, " address ACK"}, ack_r[0], 1);
        chk(ack_r[1] & ack_r[2] & ack_r[3], "R7 data ACKs", {ack_r[1], ack_r[2], ack_r[3]}, 3'b111);
        chk(strobes == s0 + 1, "R7 single strobe", strobes - s0, 1);
        chk(last_word == ew, "R2 R7 word order", last_word, ew);
    endtask

    initial begin
        int s0;
        logic [6:0] own, bad;
        logic ak;
        void'($urandom(32'h5eed1234));
        wt(5);
        chk(sda_pull_o == 0 && word_vld_o == 0 && word_o == 0, "R12 reset state",
            {sda_pull_o, word_vld_o, word_o}, 0);
        rst_n = 1'b1;
        wt(5);

        // Directed strap corners, then random strap codes (R9, R3).
        st2 = 0; st1 = 0; st0 = 0; wt(4);
        chk(exp_addr(st2, st1, st0) == 7'h10, "R9 all-ground address", exp_addr(st2, st1, st0), 7'h10);
        good_write(7'h10, "R3 R9 ground straps");
        st2 = 2; st1 = 2; st0 = 2; wt(4);
        good_write(7'h72, "R3 R9 supply straps");
        st2 = 1; st1 = 3; st0 = 1; wt(4);
        good_write(7'h41, "R9 code 11 as floating");
        for (int k = 0; k < 10; k++) begin
            st2 = 2'($urandom); st1 = 2'($urandom); st0 = 2'($urandom); wt(4);
            good_write(exp_addr(st2, st1, st0), "R3 R9 random straps");
        end

        own = exp_addr(st2, st1, st0);

        // Global address (R4).
        good_write(7'h73, "R4 global");

        // Foreign address (R6).
        do bad = 7'($urandom); while (bad == own || bad == 7'h73);
        s0 = strobes;
        xfer(bad, 1'b0, 3);
        chk(ack_r[0] == 0, "R6 foreign address NACK", ack_r[0], 0);
        chk(!(ack_r[1] | ack_r[2] | ack_r[3]), "R6 following bytes NACK", {ack_r[1], ack_r[2], ack_r[3]}, 0);
        chk(strobes == s0, "R6 no strobe", strobes - s0, 0);

        // Read requests (R5), to own and global address.
        xfer(own, 1'b1, 2);
        chk(ack_r[0] == 0 && ack_r[1] == 0 && ack_r[2] == 0, "R5 read own NACK", {ack_r[0], ack_r[1], ack_r[2]}, 0);
        xfer(7'h73, 1'b1, 1);
        chk(ack_r[0] == 0 && ack_r[1] == 0, "R5 read global NACK", {ack_r[0], ack_r[1]}, 0);

        // Extra bytes (R8).
        for (int i = 0; i < 5; i++) tx[i] = 8'($urandom);
        s0 = strobes;
        xfer(own, 1'b0, 5);
        chk(ack_r[1] & ack_r[2] & ack_r[3], "R8 first three ACK", {ack_r[1], ack_r[2], ack_r[3]}, 3'b111);
        chk(!(ack_r[4] | ack_r[5]), "R8 extra bytes NACK", {ack_r[4], ack_r[5]}, 0);
        chk(strobes == s0 + 1, "R8 one strobe only", strobes - s0, 1);
        chk(last_word == {tx[0], tx[1], tx[2]}, "R8 word unchanged by extras", last_word, {tx[0], tx[1], tx[2]});

        // STOP in the middle of the third byte (R10, R1).
        s0 = strobes;
        bus_start();
        send_bits({own, 1'b0}, 8); ack_slot(ak);
        send_bits(8'hA5, 8); ack_slot(ak);
        send_bits(8'h5A, 8); ack_slot(ak);
        send_bits(8'hFF, 4);
        bus_stop();
        wt(4);
        chk(strobes == s0, "R10 STOP mid-byte no strobe", strobes - s0, 0);
        chk(sda_pull_o == 0, "R1 released after STOP", sda_pull_o, 0);

        // Bytes with no START are ignored (R1).
        send_bits({own, 1'b0}, 8); ack_slot(ak);
        chk(ak == 0, "R1 no ACK without START", ak, 0);
        bus_stop();

        // Repeated START in the middle of a byte, then a fresh address (R10).
        s0 = strobes;
        bus_start();
        send_bits({own, 1'b0}, 8); ack_slot(ak);
        send_bits(8'h11, 8); ack_slot(ak);
        send_bits(8'h22, 5);
        bus_start();
        send_bits({own, 1'b0}, 8); ack_slot(ak);
        chk(ak == 1, "R10 fresh address after repeated START", ak, 1);
        tx[0] = 8'h3C; tx[1] = 8'hC3; tx[2] = 8'h96;
        for (int i = 0; i < 3; i++) begin
            send_bits(tx[i], 8); ack_slot(ak);
        end
        bus_stop();
        chk(strobes == s0 + 1, "R10 only the restarted word strobes", strobes - s0, 1);
        chk(last_word == 24'h3CC396, "R10 restarted word", last_word, 24'h3CC396);

        wt(4);
        chk(pull_bad == 0, "R11 pull changes only with SCL low", pull_bad, 0);

        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule